// File: doc/BRIEF.md
# NAND Sector Hamming ECC Engine

This block computes a single-error-correcting parity code over one NAND sector while the sector's bytes go past it, one byte in each cycle that carries a valid strobe. When the last byte has been seen, the block presents a 24-bit code in inverted form. A sector of erased flash (every byte 0xFF) therefore produces the code 0xFFFFFF, which is exactly what erased spare bytes read back. The code is also sent out one byte per cycle, least significant byte first, so it can be written straight into the spare area.

When the sector is read back, the same stream runs through the engine again and then the code read from the spare area is presented on the check port. One cycle later the block classifies the difference between the two codes:
- clean;
- one flipped data bit, given as a byte index and a bit index;
- one flipped bit in the stored code itself, which needs no data change;
- uncorrectable.

The block only reports the location. Flipping the bit in the sector buffer is left to the user.

Top module: `nand_hamming_ecc`

## Requirements
- R1: After reset, code_valid, code_byte_valid and res_valid are low and code_out is 0xFFFFFF.
- R2: For a sector with bytes indexed from 0, define each set data bit's 12-bit position as {byte index (9 bits), bit index (3 bits)}. Let P be the XOR of all these positions and Q the XOR of their bitwise complements. Then code_out = ~{P, Q}, with P in bits 23:12.
- R3: A valid byte with in_start high opens a new sector at byte index 0. Bytes taken before it, in a sector that was not closed, do not affect the code.
- R4: code_valid is a one-cycle pulse in the cycle after the valid byte that carries in_last. code_out holds its value until the next sector closes.
- R5: The code is also emitted on code_byte over three consecutive cycles with code_byte_valid high, least significant byte first. The first of these cycles is the code_valid cycle.
- R6: A sector of 0xFF bytes yields code_out = 0xFFFFFF, and checking it against 0xFFFFFF gives clean.
- R7: res_valid pulses one cycle after chk_valid. With diff = chk_code XOR code_out (taken at the chk_valid cycle), diff = 0 gives res_kind 0 (clean).
- R8: If diff[23:12] XOR diff[11:0] is all ones, the result is res_kind 1 (data fix) with res_byte = diff[23:15] and res_bit = diff[14:12].
- R9: A data-fix location whose byte index is not below SECTOR_BYTES is reported as res_kind 3 (uncorrectable).
- R10: A diff with exactly one bit set gives res_kind 2 (code fix).
- R11: Any other nonzero diff gives res_kind 3. Whenever res_kind is not 1, res_byte and res_bit are zero.
- R12: While in_valid is low, in_data, in_start and in_last have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sector byte present |
| in_start | input | 1 | Byte is the first of a sector |
| in_last | input | 1 | Byte is the last of a sector |
| in_data | input | 8 | Sector byte |
| code_valid | output | 1 | Pulse: code_out updated |
| code_out | output | 24 | Inverted parity code of the last sector |
| code_byte_valid | output | 1 | Serial code byte present |
| code_byte | output | 8 | Serial code byte, least significant first |
| chk_valid | input | 1 | Stored code present |
| chk_code | input | 24 | Code read from the spare area |
| res_valid | output | 1 | Pulse: classification present |
| res_kind | output | 2 | 0 clean, 1 data fix, 2 code fix, 3 uncorrectable |
| res_byte | output | 9 | Byte index of the bad data bit |
| res_bit | output | 3 | Bit index of the bad data bit |

## Verification
If the byte counter or a parity half is corrupted, code_out is wrong in the cycle after the sector closes. The most likely symptom of a wrong counter is a wrong byte index on a data fix. If an inversion is left out or a half is misplaced, an erased sector stops checking clean, and a single data flip is classified as uncorrectable instead of being located. Both show up within one cycle of the check strobe. A bad step in the serializer produces a wrong or reordered code byte in the two cycles after code_valid.

// File: rtl/necc_pkg.sv
package necc_pkg;

    localparam int BYTE_IDX_W = 9;
    localparam int BIT_IDX_W  = 3;
    localparam int POS_W      = BYTE_IDX_W + BIT_IDX_W;
    localparam int CODE_W     = 2 * POS_W;
    localparam int CODE_BYTES = CODE_W / 8;

    typedef enum logic [1:0] {
        ECC_CLEAN    = 2'd0,
        ECC_DATA_FIX = 2'd1,
        ECC_CODE_FIX = 2'd2,
        ECC_UNCORR   = 2'd3
    } ecc_kind_e;

    typedef struct packed {
        logic [POS_W-1:0] hi;   // XOR of set-bit positions
        logic [POS_W-1:0] lo;   // XOR of complemented positions
    } parity_t;

    // Parity contribution of one byte placed at a given sector index
    function automatic parity_t byte_contrib(input logic [BYTE_IDX_W-1:0] idx,
                                             input logic [7:0] data);
        parity_t          acc;
        logic [POS_W-1:0] pos;
        acc = '0;
        for (int i = 0; i < 8; i++) begin
            pos = {idx, BIT_IDX_W'(i)};
            if (data[i]) begin
                acc.hi = acc.hi ^ pos;
                acc.lo = acc.lo ^ ~pos;
            end
        end
        return acc;
    endfunction

endpackage

// File: rtl/necc_parity_acc.sv
module necc_parity_acc
    import necc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic       in_start,
    input  logic       in_last,
    input  logic [7:0] in_data,
    output logic       fin_valid_o,
    output parity_t    fin_par_o
);

    typedef struct packed {
        logic [BYTE_IDX_W-1:0] idx;
        parity_t               par;
    } acc_t;

    acc_t                  st_d, st_q;
    logic [BYTE_IDX_W-1:0] idx_eff;
    parity_t               base;
    parity_t               sum;

    always_comb begin
        st_d    = st_q;
        idx_eff = in_start ? '0 : st_q.idx;
        base    = in_start ? '0 : st_q.par;
        sum     = base ^ byte_contrib(idx_eff, in_data);
        if (in_valid) begin
            if (in_last) begin
                st_d.idx = '0;
                st_d.par = '0;
            end else begin
                st_d.idx = idx_eff + 1'b1;
                st_d.par = sum;
            end
        end
        fin_valid_o = in_valid && in_last;
        fin_par_o   = sum;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/necc_code_out.sv
module necc_code_out
    import necc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fin_valid_i,
    input  parity_t           fin_par_i,
    output logic              code_valid_o,
    output logic [CODE_W-1:0] code_o,
    output logic              byte_valid_o,
    output logic [7:0]        byte_o
);

    localparam int IDX_W = $clog2(CODE_BYTES);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(CODE_BYTES - 1);

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              code_vld;
        logic              emit_on;
        logic [IDX_W-1:0]  emit_idx;
    } pk_t;

    pk_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.code_vld = 1'b0;
        if (st_q.emit_on) begin
            if (st_q.emit_idx == IDX_LAST) st_d.emit_on = 1'b0;
            else                           st_d.emit_idx = st_q.emit_idx + 1'b1;
        end
        if (fin_valid_i) begin
            st_d.code     = ~fin_par_i;
            st_d.code_vld = 1'b1;
            st_d.emit_on  = 1'b1;
            st_d.emit_idx = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.code <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign code_valid_o = st_q.code_vld;
    assign code_o       = st_q.code;
    assign byte_valid_o = st_q.emit_on;
    assign byte_o       = st_q.code[8*st_q.emit_idx +: 8];

endmodule

// File: rtl/necc_classify.sv
module necc_classify
    import necc_pkg::*;
#(
    parameter int SECTOR_BYTES = 512
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  chk_valid,
    input  logic [CODE_W-1:0]     chk_code,
    input  logic [CODE_W-1:0]     code_ref,
    output logic                  res_valid,
    output logic [1:0]            res_kind,
    output logic [BYTE_IDX_W-1:0] res_byte,
    output logic [BIT_IDX_W-1:0]  res_bit
);

    localparam logic [BYTE_IDX_W:0] LIMIT = (BYTE_IDX_W+1)'(SECTOR_BYTES);

    typedef struct packed {
        logic                  vld;
        ecc_kind_e             kind;
        logic [BYTE_IDX_W-1:0] byte_idx;
        logic [BIT_IDX_W-1:0]  bit_idx;
    } cls_t;

    cls_t              st_d, st_q;
    logic [CODE_W-1:0] diff;
    logic [POS_W-1:0]  syn;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        diff     = chk_code ^ code_ref;
        syn      = diff[CODE_W-1:POS_W] ^ diff[POS_W-1:0];
        if (chk_valid) begin
            st_d.vld      = 1'b1;
            st_d.byte_idx = '0;
            st_d.bit_idx  = '0;
            if (diff == '0) begin
                st_d.kind = ECC_CLEAN;
            end else if (syn == '1) begin
                if ({1'b0, diff[CODE_W-1 -: BYTE_IDX_W]} < LIMIT) begin
                    st_d.kind     = ECC_DATA_FIX;
                    st_d.byte_idx = diff[CODE_W-1 -: BYTE_IDX_W];
                    st_d.bit_idx  = diff[POS_W +: BIT_IDX_W];
                end else begin
                    st_d.kind = ECC_UNCORR;
                end
            end else if ($onehot(diff)) begin
                st_d.kind = ECC_CODE_FIX;
            end else begin
                st_d.kind = ECC_UNCORR;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_valid = st_q.vld;
    assign res_kind  = st_q.kind;
    assign res_byte  = st_q.byte_idx;
    assign res_bit   = st_q.bit_idx;

endmodule

// File: rtl/nand_hamming_ecc.sv
module nand_hamming_ecc #(
    parameter int SECTOR_BYTES = 512
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic        in_start,
    input  logic        in_last,
    input  logic [7:0]  in_data,
    output logic        code_valid,
    output logic [23:0] code_out,
    output logic        code_byte_valid,
    output logic [7:0]  code_byte,
    input  logic        chk_valid,
    input  logic [23:0] chk_code,
    output logic        res_valid,
    output logic [1:0]  res_kind,
    output logic [8:0]  res_byte,
    output logic [2:0]  res_bit
);

    necc_pkg::parity_t fin_par;
    logic              fin_valid;

    necc_parity_acc u_acc (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_start    (in_start),
        .in_last     (in_last),
        .in_data     (in_data),
        .fin_valid_o (fin_valid),
        .fin_par_o   (fin_par)
    );

    necc_code_out u_out (
        .clk          (clk),
        .rst_n        (rst_n),
        .fin_valid_i  (fin_valid),
        .fin_par_i    (fin_par),
        .code_valid_o (code_valid),
        .code_o       (code_out),
        .byte_valid_o (code_byte_valid),
        .byte_o       (code_byte)
    );

    necc_classify #(.SECTOR_BYTES(SECTOR_BYTES)) u_cls (
        .clk       (clk),
        .rst_n     (rst_n),
        .chk_valid (chk_valid),
        .chk_code  (chk_code),
        .code_ref  (code_out),
        .res_valid (res_valid),
        .res_kind  (res_kind),
        .res_byte  (res_byte),
        .res_bit   (res_bit)
    );

endmodule

// File: rtl/necc_checker.sv
module necc_checker #(
    parameter int SECTOR_BYTES = 512
) (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_last,
    input logic        code_valid,
    input logic [23:0] code_out,
    input logic        code_byte_valid,
    input logic [7:0]  code_byte,
    input logic        chk_valid,
    input logic [23:0] chk_code,
    input logic        res_valid,
    input logic [1:0]  res_kind,
    input logic [8:0]  res_byte,
    input logic [2:0]  res_bit
);

    localparam logic [9:0] LIMIT = 10'(SECTOR_BYTES);

    a_r4_code_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_last) |=> code_valid);

    a_r4_no_spurious_code: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid |-> $past(in_valid && in_last));

    a_r4_code_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !code_valid |-> $stable(code_out));

    a_r5_first_byte: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid |-> (code_byte_valid && code_byte == code_out[7:0]));

    a_r7_result_lag: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid |=> res_valid);

    a_r7_no_spurious_result: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(chk_valid));

    a_r7_clean_means_equal: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_kind == 2'd0) |-> ($past(chk_code) == $past(code_out)));

    a_r9_fix_in_sector: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_kind == 2'd1) |-> ({1'b0, res_byte} < LIMIT));

    a_r10_code_fix_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_kind == 2'd2) |->
            ($countones($past(chk_code) ^ $past(code_out)) == 1));

    a_r11_zero_location: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_kind != 2'd1) |-> (res_byte == '0 && res_bit == '0));

endmodule

bind nand_hamming_ecc necc_checker #(.SECTOR_BYTES(SECTOR_BYTES)) u_necc_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .in_valid        (in_valid),
    .in_last         (in_last),
    .code_valid      (code_valid),
    .code_out        (code_out),
    .code_byte_valid (code_byte_valid),
    .code_byte       (code_byte),
    .chk_valid       (chk_valid),
    .chk_code        (chk_code),
    .res_valid       (res_valid),
    .res_kind        (res_kind),
    .res_byte        (res_byte),
    .res_bit         (res_bit)
);

// File: tb/nand_hamming_ecc_tb_top.sv
module nand_hamming_ecc_tb_top;

    localparam int SHORT_BYTES = 300;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_start = 1'b0, in_last = 1'b0;
    logic [7:0]  in_data = '0;
    logic        chk_valid = 1'b0;
    logic [23:0] chk_code = '0;

    logic        code_valid, code_byte_valid, res_valid;
    logic [23:0] code_out;
    logic [7:0]  code_byte;
    logic [1:0]  res_kind;
    logic [8:0]  res_byte;
    logic [2:0]  res_bit;

    logic        s_code_valid, s_code_byte_valid, s_res_valid;
    logic [23:0] s_code_out;
    logic [7:0]  s_code_byte;
    logic [1:0]  s_res_kind;
    logic [8:0]  s_res_byte;
    logic [2:0]  s_res_bit;

    int   n_checks = 0;
    int   n_fails  = 0;
    bit   finished = 1'b0;
    logic [7:0] sec [512];

    always #4 clk = ~clk;   // 125 MHz

    nand_hamming_ecc dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
        .in_last(in_last), .in_data(in_data), .code_valid(code_valid),
        .code_out(code_out), .code_byte_valid(code_byte_valid), .code_byte(code_byte),
        .chk_valid(chk_valid), .chk_code(chk_code), .res_valid(res_valid),
        .res_kind(res_kind), .res_byte(res_byte), .res_bit(res_bit)
    );

    nand_hamming_ecc #(.SECTOR_BYTES(SHORT_BYTES)) dut_short_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
        .in_last(in_last), .in_data(in_data), .code_valid(s_code_valid),
        .code_out(s_code_out), .code_byte_valid(s_code_byte_valid), .code_byte(s_code_byte),
        .chk_valid(chk_valid), .chk_code(chk_code), .res_valid(s_res_valid),
        .res_kind(s_res_kind), .res_byte(s_res_byte), .res_bit(s_res_bit)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [23:0] model_code(int n);
        logic [11:0] hi = '0, lo = '0, pos;
        for (int b = 0; b < n; b++)
            for (int i = 0; i < 8; i++)
                if (sec[b][i]) begin
                    pos = {9'(b), 3'(i)};
                    hi  = hi ^ pos;
                    lo  = lo ^ ~pos;
                end
        return ~{hi, lo};
    endfunction

    // returns {kind, byte, bit}
    function automatic logic [13:0] model_class(logic [23:0] diff, int limit);
        logic [11:0] syn = diff[23:12] ^ diff[11:0];
        if (diff == 0) return {2'd0, 12'd0};
        if (syn == 12'hfff) begin
            if (int'(diff[23:15]) < limit) return {2'd1, diff[23:15], diff[14:12]};
            return {2'd3, 12'd0};
        end
        if ($countones(diff) == 1) return {2'd2, 12'd0};
        return {2'd3, 12'd0};
    endfunction

    task automatic idle_garbage();
        @(negedge clk);
        in_valid = 1'b0;
        in_start = 1'($urandom);
        in_last  = 1'($urandom);
        in_data  = 8'($urandom);
    endtask

    // stream sec[0..n-1]; with do_last, check the code outputs (R2, R4, R5)
    task automatic send_sector(int n, bit gaps, bit do_last, string req);
        logic [23:0] exp;
        for (int b = 0; b < n; b++) begin
            if (gaps && ($urandom % 4 == 0)) idle_garbage();   // R12
            @(negedge clk);
            in_valid = 1'b1;
            in_start = (b == 0);
            in_last  = do_last && (b == n - 1);
            in_data  = sec[b];
        end
        @(negedge clk);
        in_valid = 1'b0; in_start = 1'b0; in_last = 1'b0;
        if (!do_last) return;
        exp = model_code(n);
        check("R4", "code_valid pulse", 32'(code_valid), 1);
        check(req, "code_out", 32'(code_out), 32'(exp));
        check("R5", "byte0", {23'd0, code_byte_valid, code_byte}, {23'd0, 1'b1, exp[7:0]});
        @(negedge clk);
        check("R4", "code_valid drop", 32'(code_valid), 0);
        check("R5", "byte1", {23'd0, code_byte_valid, code_byte}, {23'd0, 1'b1, exp[15:8]});
        @(negedge clk);
        check("R5", "byte2", {23'd0, code_byte_valid, code_byte}, {23'd0, 1'b1, exp[23:16]});
        @(negedge clk);
        check("R5", "serial end", 32'(code_byte_valid), 0);
        check("R4", "code held", 32'(code_out), 32'(exp));
    endtask

    task automatic run_check(logic [23:0] stored, string req);
        logic [13:0] exp, exp_s;
        logic [23:0] cur = code_out;
        exp   = model_class(stored ^ cur, 512);
        exp_s = model_class(stored ^ cur, SHORT_BYTES);
        @(negedge clk);
        chk_valid = 1'b1;
        chk_code  = stored;
        @(negedge clk);
        chk_valid = 1'b0;
        check("R7", "res_valid", 32'(res_valid), 1);
        check(req, "result", 32'({res_kind, res_byte, res_bit}), 32'(exp));
        check(req, "short result", 32'({s_res_kind, s_res_byte, s_res_bit}), 32'(exp_s));
    endtask

    task automatic fill_random(int n);
        for (int b = 0; b < n; b++) sec[b] = 8'($urandom);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    initial begin
        logic [23:0] good, pos24;
        int bb, bi, bb2, bi2;
        void'($urandom(32'd7741));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", "code_valid", 32'(code_valid), 0);
        check("R1", "code_byte_valid", 32'(code_byte_valid), 0);
        check("R1", "res_valid", 32'(res_valid), 0);
        check("R1", "code_out", 32'(code_out), 32'h00ffffff);
        run_check(24'hffffff, "R7");

        // R6 erased sector
        for (int b = 0; b < 512; b++) sec[b] = 8'hff;
        send_sector(512, 1'b0, 1'b1, "R6");
        check("R6", "erased code", 32'(code_out), 32'h00ffffff);
        run_check(24'hffffff, "R6");

        // R2 directed: single bit at byte 1 bit 0, and a one-byte sector
        for (int b = 0; b < 512; b++) sec[b] = 8'h00;
        sec[1] = 8'h01;
        send_sector(512, 1'b0, 1'b1, "R2");
        sec[0] = 8'h80;
        send_sector(1, 1'b0, 1'b1, "R2");

        // R2/R12 random sectors with idle garbage gaps
        for (int k = 0; k < 3; k++) begin
            fill_random(512);
            send_sector(512, 1'b1, 1'b1, "R2");
            run_check(code_out, "R7");
        end

        // R3 unfinished sector then a fresh start
        fill_random(512);
        send_sector(57, 1'b1, 1'b0, "R3");
        fill_random(512);
        send_sector(200, 1'b0, 1'b1, "R3");

        // R8 single data-bit flips
        for (int k = 0; k < 5; k++) begin
            fill_random(512);
            good = model_code(512);
            bb = $urandom % 512; bi = $urandom % 8;
            sec[bb][bi] = ~sec[bb][bi];
            send_sector(512, 1'b0, 1'b1, "R2");
            run_check(good, "R8");
            check("R8", "location", 32'({res_byte, res_bit}), 32'({9'(bb), 3'(bi)}));
        end

        // R10 one flipped bit in the stored code
        for (int k = 0; k < 4; k++) begin
            good = code_out;
            run_check(good ^ (24'd1 << ($urandom % 24)), "R10");
            check("R10", "kind", 32'(res_kind), 2);
        end

        // R11 two data flips, multi-bit code damage
        fill_random(512);
        good = model_code(512);
        bb = 10; bi = 3; bb2 = 400; bi2 = 6;
        sec[bb][bi] = ~sec[bb][bi];
        sec[bb2][bi2] = ~sec[bb2][bi2];
        send_sector(512, 1'b0, 1'b1, "R2");
        run_check(good, "R11");
        check("R11", "two flips", 32'({res_kind, res_byte, res_bit}), 32'({2'd3, 12'd0}));
        run_check(code_out ^ 24'h000007, "R11");

        // R9 location beyond the short sector
        fill_random(SHORT_BYTES);
        send_sector(SHORT_BYTES, 1'b0, 1'b1, "R2");
        pos24 = {12'({9'd400, 3'd2}), ~12'({9'd400, 3'd2})};
        run_check(code_out ^ pos24, "R9");
        check("R9", "short uncorrectable", 32'(s_res_kind), 3);
        check("R9", "full fixes byte 400", 32'({res_kind, res_byte}), 32'({2'd1, 9'd400}));
        pos24 = {12'({9'd299, 3'd7}), ~12'({9'd299, 3'd7})};
        run_check(code_out ^ pos24, "R9");
        check("R9", "short last byte fix", 32'({s_res_kind, s_res_byte, s_res_bit}),
              32'({2'd1, 9'd299, 3'd7}));

        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule